// File: doc/BRIEF.md
# Carry-as-Not-Borrow Add/Subtract/Compare Unit

This block is the arithmetic core of a small 8-bit datapath. It performs add-with-carry, subtract-with-carry and compare, all on a single binary adder. Subtraction feeds the adder the bitwise inverse of the second operand and takes the incoming carry flag without change as a "no borrow" indication. The carry that comes out therefore reads 1 when no borrow happened and 0 when one did. Because no carry inverter and no separate borrow chain exist, there is no carry-free add or subtract operation. Software sets or clears the carry before it starts a chain of add or subtract steps.

Compare is a subtraction whose carry-in is tied to 1, whatever carry value is presented. It produces N, Z and C, raises no result write strobe, and leaves V out of its update mask. A fourth code passes the first operand through and updates no flag. No shift operation is provided, arithmetic shift right included.

Every output is registered, so a result appears one clock after its operands. Alongside the result the block gives the four flag values, a mask that says which of them the operation updates, and a write strobe for the result.

Top module: `cbr_alu`

## Requirements
- R1: With op 2'b00 (add), the result is (A + B + Cin) mod 2^W and C is bit W of that sum.
- R2: With op 2'b01 (subtract), the result is (A + ~B + Cin) mod 2^W, which equals A - B - (1 - Cin). Cin = 1 therefore means no borrow.
- R3: After a subtract, C is 1 when A >= B + (1 - Cin) as unsigned values (no borrow), and 0 otherwise.
- R4: With op 2'b10 (compare), the carry-in is forced to 1 whatever Cin holds. C = (A >= B) unsigned, Z = (A == B), and N = bit W-1 of A - B.
- R5: Compare drives the result write strobe low and the update mask to N,Z,C only (mask 4'b1110).
- R6: V is 1 when A and the adder's second input (B for add, ~B for subtract and compare) have the same sign bit and the sign bit of the result differs from it.
- R7: N equals bit W-1 of the result, and Z is 1 exactly when the W-bit result is zero.
- R8: With op 2'b11 (pass), the result equals A, the update mask is 4'b0000 and the write strobe is 1.
- R9: The update mask is ordered {N, Z, C, V} from bit 3 down to bit 0. Add and subtract give mask 4'b1111 and write strobe 1.
- R10: Outputs change one clock after the inputs are sampled. While reset is asserted, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_i | input | 2 | Operation code: 00 add, 01 subtract, 10 compare, 11 pass |
| a_i | input | W | First operand |
| b_i | input | W | Second operand |
| c_i | input | 1 | Incoming carry flag (not-borrow for subtract) |
| res_o | output | W | Registered result |
| n_o | output | 1 | Negative flag |
| z_o | output | 1 | Zero flag |
| c_o | output | 1 | Carry / not-borrow flag |
| v_o | output | 1 | Signed overflow flag |
| upd_o | output | 4 | Flag update mask {N,Z,C,V} |
| wr_o | output | 1 | Result write strobe |

## Verification
The bench builds the unit at the default width of 8. At that width the signed limits 0x7F and 0x80, the all-ones wrap and the equal-operand compare are reachable with directed operands. A directed set covers the borrow boundaries: A - B with Cin clear against A - B with Cin set, and a result that lands exactly on zero. The set also runs compare with both carry values, to show that the incoming carry has no effect. A few thousand random operations then cover all four codes against an independent integer model, which works out signed overflow from range limits rather than from sign bits.

// File: rtl/cbr_pkg.sv
package cbr_pkg;
    typedef enum logic [1:0] {
        OP_ADC  = 2'b00,
        OP_SBC  = 2'b01,
        OP_CMP  = 2'b10,
        OP_PASS = 2'b11
    } cbr_op_e;

    localparam int MASK_W = 4;
    localparam logic [MASK_W-1:0] MASK_ALL  = 4'b1111;
    localparam logic [MASK_W-1:0] MASK_NZC  = 4'b1110;
    localparam logic [MASK_W-1:0] MASK_NONE = 4'b0000;
endpackage

// File: rtl/cbr_operand_prep.sv
module cbr_operand_prep
    import cbr_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [1:0]   op_i,
    input  logic [W-1:0] b_i,
    input  logic         c_i,
    output logic [W-1:0] opnd_o,
    output logic         cin_o
);
    always_comb begin
        opnd_o = b_i;
        cin_o  = c_i;
        case (cbr_op_e'(op_i))
            OP_ADC:  begin opnd_o = b_i;  cin_o = c_i;  end
            OP_SBC:  begin opnd_o = ~b_i; cin_o = c_i;  end
            OP_CMP:  begin opnd_o = ~b_i; cin_o = 1'b1; end
            default: begin opnd_o = b_i;  cin_o = 1'b0; end
        endcase
    end
endmodule

// File: rtl/cbr_adder.sv
module cbr_adder #(
    parameter int W = 8
) (
    input  logic [W-1:0] x_i,
    input  logic [W-1:0] y_i,
    input  logic         cin_i,
    output logic [W-1:0] sum_o,
    output logic         cout_o
);
    logic [W:0] chain;
    assign chain[0] = cin_i;

    for (genvar i = 0; i < W; i++) begin : g_bit
        assign sum_o[i]    = x_i[i] ^ y_i[i] ^ chain[i];
        assign chain[i+1]  = (x_i[i] & y_i[i]) | (chain[i] & (x_i[i] ^ y_i[i]));
    end

    assign cout_o = chain[W];
endmodule

// File: rtl/cbr_flags.sv
module cbr_flags #(
    parameter int W = 8
) (
    input  logic         x_msb_i,
    input  logic         y_msb_i,
    input  logic [W-1:0] sum_i,
    input  logic         cout_i,
    output logic         n_o,
    output logic         z_o,
    output logic         c_o,
    output logic         v_o
);
    always_comb begin
        n_o = sum_i[W-1];
        z_o = (sum_i == '0);
        c_o = cout_i;
        v_o = (x_msb_i == y_msb_i) && (sum_i[W-1] != x_msb_i);
    end
endmodule

// File: rtl/cbr_alu.sv
module cbr_alu
    import cbr_pkg::*;
#(
    parameter int W = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    op_i,
    input  logic [W-1:0]  a_i,
    input  logic [W-1:0]  b_i,
    input  logic          c_i,
    output logic [W-1:0]  res_o,
    output logic          n_o,
    output logic          z_o,
    output logic          c_o,
    output logic          v_o,
    output logic [3:0]    upd_o,
    output logic          wr_o
);
    typedef struct packed {
        logic [W-1:0]      res;
        logic              n;
        logic              z;
        logic              c;
        logic              v;
        logic [MASK_W-1:0] upd;
        logic              wr;
    } state_t;

    state_t st_d, st_q;

    logic [W-1:0] opnd;
    logic         cin;
    logic [W-1:0] sum;
    logic         cout;
    logic         fn, fz, fc, fv;

    cbr_operand_prep #(.W(W)) u_prep (
        .op_i(op_i), .b_i(b_i), .c_i(c_i), .opnd_o(opnd), .cin_o(cin)
    );

    cbr_adder #(.W(W)) u_add (
        .x_i(a_i), .y_i(opnd), .cin_i(cin), .sum_o(sum), .cout_o(cout)
    );

    cbr_flags #(.W(W)) u_flags (
        .x_msb_i(a_i[W-1]), .y_msb_i(opnd[W-1]), .sum_i(sum), .cout_i(cout),
        .n_o(fn), .z_o(fz), .c_o(fc), .v_o(fv)
    );

    always_comb begin
        st_d     = st_q;
        st_d.res = sum;
        st_d.n   = fn;
        st_d.z   = fz;
        st_d.c   = fc;
        st_d.v   = fv;
        case (cbr_op_e'(op_i))
            OP_ADC, OP_SBC: begin
                st_d.upd = MASK_ALL;
                st_d.wr  = 1'b1;
            end
            OP_CMP: begin
                st_d.upd = MASK_NZC;
                st_d.wr  = 1'b0;
            end
            default: begin
                st_d.res = a_i;
                st_d.n   = a_i[W-1];
                st_d.z   = (a_i == '0);
                st_d.c   = 1'b0;
                st_d.v   = 1'b0;
                st_d.upd = MASK_NONE;
                st_d.wr  = 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign res_o = st_q.res;
    assign n_o   = st_q.n;
    assign z_o   = st_q.z;
    assign c_o   = st_q.c;
    assign v_o   = st_q.v;
    assign upd_o = st_q.upd;
    assign wr_o  = st_q.wr;

    // Assertions: armed one clock after reset release so $past sees driven inputs.
    logic armed_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) armed_q <= 1'b0;
        else        armed_q <= 1'b1;
    end

    assert_adc_sum_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && $past(op_i) == OP_ADC) |->
        ({c_o, res_o} == ({1'b0, $past(a_i)} + {1'b0, $past(b_i)} + {{W{1'b0}}, $past(c_i)})));

    assert_sbc_sum_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && $past(op_i) == OP_SBC) |->
        ({c_o, res_o} == ({1'b0, $past(a_i)} + {1'b0, ~$past(b_i)} + {{W{1'b0}}, $past(c_i)})));

    assert_cmp_carry_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && $past(op_i) == OP_CMP) |->
        (c_o == ($past(a_i) >= $past(b_i)) && z_o == ($past(a_i) == $past(b_i))));

    assert_cmp_nowrite_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && $past(op_i) == OP_CMP) |-> (!wr_o && upd_o == MASK_NZC));

    assert_pass_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && $past(op_i) == OP_PASS) |->
        (res_o == $past(a_i) && upd_o == MASK_NONE && wr_o));

    assert_zero_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_o[2]) |-> (z_o == (res_o == '0) && n_o == res_o[W-1]));

    assert_cmp_no_v_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_o) |-> !upd_o[0]);
endmodule

// File: tb/tb_cbr_alu.sv
module tb_cbr_alu;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n;
    logic [1:0]   op;
    logic [W-1:0] a, b;
    logic         cin;
    logic [W-1:0] res;
    logic         n, z, c, v, wr;
    logic [3:0]   upd;

    always #5 clk = ~clk;

    cbr_alu #(.W(W)) dut (
        .clk(clk), .rst_n(rst_n), .op_i(op), .a_i(a), .b_i(b), .c_i(cin),
        .res_o(res), .n_o(n), .z_o(z), .c_o(c), .v_o(v), .upd_o(upd), .wr_o(wr)
    );

    typedef struct {
        logic [1:0]   op;
        logic [W-1:0] res;
        logic         n, z, c, v, wr;
        logic [3:0]   upd;
    } exp_t;

    exp_t q[$];
    int compared = 0;
    int mismatched = 0;
    bit done = 0;

    function automatic exp_t model(logic [1:0] o, logic [W-1:0] x, logic [W-1:0] y, logic ci);
        exp_t e;
        int s, sv, sx, sy;
        sx = $signed(x);
        sy = $signed(y);
        e.op = o;
        case (o)
            2'b00: begin
                s = int'(x) + int'(y) + int'(ci);
                sv = sx + sy + int'(ci);
                e.c = (s > 255); e.upd = 4'b1111; e.wr = 1'b1;
            end
            2'b01: begin
                s = int'(x) - int'(y) - (1 - int'(ci));
                sv = sx - sy - (1 - int'(ci));
                e.c = (s >= 0); e.upd = 4'b1111; e.wr = 1'b1;
            end
            2'b10: begin
                s = int'(x) - int'(y);
                sv = sx - sy;
                e.c = (s >= 0); e.upd = 4'b1110; e.wr = 1'b0;
            end
            default: begin
                s = int'(x); sv = 0;
                e.c = 1'b0; e.upd = 4'b0000; e.wr = 1'b1;
            end
        endcase
        e.res = s[W-1:0];
        e.v = (sv > 127) || (sv < -128);
        e.n = e.res[W-1];
        e.z = (e.res == '0);
        return e;
    endfunction

    task automatic chk(string tag, int act, int exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic drive(logic [1:0] o, logic [W-1:0] x, logic [W-1:0] y, logic ci);
        @(negedge clk);
        op = o; a = x; b = y; cin = ci;
        q.push_back(model(o, x, y, ci));
    endtask

    // Monitor: outputs registered at the posedge following the drive.
    always @(posedge clk) begin
        #2;
        if (q.size() > 0) begin
            exp_t e;
            string t;
            e = q.pop_front();
            case (e.op)
                2'b00:   t = "R1 add";
                2'b01:   t = "R2/R3 subtract";
                2'b10:   t = "R4 compare";
                default: t = "R8 pass";
            endcase
            chk({t, " result"}, int'(res), int'(e.res));
            chk({t, " R9 mask"}, int'(upd), int'(e.upd));
            chk({t, " R5 write"}, int'(wr), int'(e.wr));
            if (e.op != 2'b11) begin
                chk({t, " carry"}, int'(c), int'(e.c));
                chk({t, " R7 N"}, int'(n), int'(e.n));
                chk({t, " R7 Z"}, int'(z), int'(e.z));
                chk({t, " R6 V"}, int'(v), int'(e.v));
            end
        end
    end

    initial begin
        #1500000;
        if (!done) begin
            mismatched++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; op = 2'b00; a = '0; b = '0; cin = 1'b0;
        repeat (3) @(negedge clk);
        // R10: reset state
        chk("R10 reset result", int'(res), 0);
        chk("R10 reset mask", int'(upd), 0);
        chk("R10 reset flags", int'({n, z, c, v, wr}), 0);
        rst_n = 1'b1;

        // R1 corners
        drive(2'b00, 8'h7F, 8'h01, 1'b0);   // signed overflow R6
        drive(2'b00, 8'hFF, 8'h01, 1'b0);   // carry, zero
        drive(2'b00, 8'hFF, 8'hFF, 1'b1);
        drive(2'b00, 8'h80, 8'h80, 1'b0);   // negative overflow
        // R2/R3 borrow boundaries
        drive(2'b01, 8'h00, 8'h01, 1'b1);
        drive(2'b01, 8'h50, 8'h50, 1'b0);   // borrow in -> FF, C=0
        drive(2'b01, 8'h50, 8'h50, 1'b1);   // no borrow -> 00, C=1
        drive(2'b01, 8'h80, 8'h01, 1'b1);   // V set
        drive(2'b01, 8'h7F, 8'hFF, 1'b1);   // V set
        // R4: carry-in ignored for compare
        drive(2'b10, 8'h42, 8'h42, 1'b0);
        drive(2'b10, 8'h42, 8'h42, 1'b1);
        drive(2'b10, 8'h10, 8'h11, 1'b1);
        drive(2'b10, 8'hFF, 8'h00, 1'b0);
        // R8 pass
        drive(2'b11, 8'h00, 8'hAA, 1'b1);
        drive(2'b11, 8'h9C, 8'h33, 1'b0);

        for (int i = 0; i < 4000; i++) begin
            drive(2'($urandom_range(0, 3)), W'($urandom), W'($urandom), 1'($urandom));
        end
        @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule